// File: doc/BRIEF.md
# Two-Wire Target Shift Engine with Clock Hold

This block is the bit-level engine of a target on a two-wire bus whose clock and data lines are both open-drain. An 8-bit shift register takes in one data bit per clock period and presents its most significant bit to the data line. A 4-bit counter advances on every clock transition, rising and falling alike, so that its wrap from all-ones to zero marks the end of a frame. The host preloads the counter to set the frame length: 0 gives a full byte of 16 transitions, and 14 gives a single acknowledge bit of 2 transitions.

A clock-hold unit pulls the clock line low to make the initiator wait. It does this after a start condition until the host acknowledges the start, and after the frame-end flag has been raised once the next falling clock edge arrives, until the host clears that flag. Because the hold acts on the shared line, an initiator that checks the line after releasing it sees the stretch. A stop condition removes every hold. The block makes no decision about addresses or transfer direction. The host uses the flags, the counter preload and the data-output enable to run the protocol: a 7-bit address, then the read/write bit, then an acknowledge; or 8 data bits, most significant first, then an acknowledge.

Top module: `tws_target_engine`

## Requirements
- R1: After reset the shift register is 0x00, the counter is 0, all three flags are 0, and neither line is driven (`scl_low` = 0, `sda_low` = 0).
- R2: A rising clock edge samples the data line into a one-bit latch. A falling clock edge shifts the register left, and the latched bit enters bit 0. The first bit on the bus therefore ends up in bit 7.
- R3: The counter adds one on each rising and on each falling clock edge, and wraps from 15 to 0.
- R4: A wrap of the counter sets `ovf_flag`. A pulse on `ovf_clr` clears it. If a wrap and `ovf_clr` fall in the same cycle, the flag ends up set.
- R5: A pulse on `cnt_wr` loads `cnt_wdata` and takes priority over a clock edge in the same cycle. A preload of 14 sets `ovf_flag` after two clock edges, and a preload of 0 sets it after sixteen.
- R6: A falling clock edge while `ovf_flag` is set, including the falling edge that causes the wrap, makes `scl_low` 1. `scl_low` stays 1 until `ovf_flag` is cleared.
- R7: A start condition is the data line falling while the clock line is high in both this sample and the previous one. It sets `start_flag`, zeroes the counter and makes `scl_low` 1. A pulse on `start_clr` clears the flag and the hold.
- R8: A stop condition is the data line rising while the clock line is high in both this sample and the previous one. It sets `stop_flag`, which `stop_clr` clears, and it removes both clock holds.
- R9: `sda_low` is 1 exactly when `sda_oe` is 1 and bit 7 of the shift register is 0.
- R10: A pulse on `sr_wr` loads `sr_wdata` and takes priority over a shift caused by a falling clock edge in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Sampled level of the bus clock line |
| sda_i | input | 1 | Sampled level of the bus data line |
| sr_wr | input | 1 | Host write strobe for the shift register |
| sr_wdata | input | 8 | Host value for the shift register |
| cnt_wr | input | 1 | Host write strobe for the edge counter |
| cnt_wdata | input | 4 | Host preload value for the edge counter |
| start_clr | input | 1 | Clears the start flag and the start hold |
| ovf_clr | input | 1 | Clears the frame-end flag and the frame-end hold |
| stop_clr | input | 1 | Clears the stop flag |
| sda_oe | input | 1 | Allows bit 7 of the shift register to drive the data line |
| sr_q | output | 8 | Shift register contents |
| cnt_q | output | 4 | Edge counter value |
| start_flag | output | 1 | Start condition seen |
| ovf_flag | output | 1 | Counter wrapped (frame complete) |
| stop_flag | output | 1 | Stop condition seen |
| scl_low | output | 1 | Open-drain pull-down enable for the clock line |
| sda_low | output | 1 | Open-drain pull-down enable for the data line |

## Verification
Two pairs of events can land in the same cycle. The first is a counter wrap together with the host clearing `ovf_flag`. The second is a falling clock edge together with a host write to the shift register or to the counter. Directed steps place each pair on one cycle on purpose, for example a rising edge on a counter preloaded to 15 with `ovf_clr` pulsed in that cycle, and check that the set and the host write take priority. A long random phase then toggles the lines and the host strobes freely, and a bench model built from the requirements judges every cycle.

// File: rtl/tws_pkg.sv
package tws_pkg;

  typedef struct packed {
    logic scl_rise;
    logic scl_fall;
    logic start;
    logic stop;
  } tws_evt_t;

  typedef enum logic [1:0] {
    CNT_KEEP,
    CNT_LOAD,
    CNT_ZERO,
    CNT_STEP
  } tws_cnt_op_e;

  // Counter update choice: host load beats start clear beats edge step.
  function automatic tws_cnt_op_e cnt_op(input logic load, input logic start,
                                         input logic edge_seen);
    if (load)           return CNT_LOAD;
    else if (start)     return CNT_ZERO;
    else if (edge_seen) return CNT_STEP;
    else                return CNT_KEEP;
  endfunction

  // Sticky flag with set priority over clear.
  function automatic logic flag_next(input logic set, input logic clr, input logic cur);
    return set | (cur & ~clr);
  endfunction

endpackage

// File: rtl/tws_edge_det.sv
module tws_edge_det
  import tws_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     scl_i,
  input  logic     sda_i,
  output tws_evt_t evt_o
);

  logic scl_q;
  logic sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_i;
      sda_q <= sda_i;
    end
  end

  always_comb begin
    evt_o.scl_rise = scl_i & ~scl_q;
    evt_o.scl_fall = ~scl_i & scl_q;
    evt_o.start    = scl_i & scl_q & sda_q & ~sda_i;
    evt_o.stop     = scl_i & scl_q & ~sda_q & sda_i;
  end

  // R7 R8
  cond_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_o.start | evt_o.stop) |-> !(evt_o.scl_rise | evt_o.scl_fall));

endmodule

// File: rtl/tws_shifter.sv
module tws_shifter #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              sda_i,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] sr_o
);

  logic              bit_q;
  logic [DATA_W-1:0] sr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_q <= 1'b0;
      sr_q  <= '0;
    end else begin
      if (scl_rise) bit_q <= sda_i;
      if (wr_en)         sr_q <= wr_data;
      else if (scl_fall) sr_q <= {sr_q[DATA_W-2:0], bit_q};
    end
  end

  assign sr_o = sr_q;

  // R10
  sr_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> sr_q == $past(wr_data));

  // R2
  sr_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_fall && !wr_en) |=> (sr_q[0] == $past(bit_q)) &&
                             (sr_q[DATA_W-1:1] == $past(sr_q[DATA_W-2:0])));

endmodule

// File: rtl/tws_counter.sv
module tws_counter
  import tws_pkg::*;
#(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             edge_seen,
  input  logic             start,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic [CNT_W-1:0] cnt_o,
  output logic             wrap_o
);

  localparam logic [CNT_W-1:0] CNT_TOP = '1;
  localparam logic [CNT_W-1:0] CNT_ONE = {{(CNT_W-1){1'b0}}, 1'b1};

  logic [CNT_W-1:0] cnt_q;
  tws_cnt_op_e      op;

  always_comb begin
    op     = cnt_op(load, start, edge_seen);
    wrap_o = (op == CNT_STEP) && (cnt_q == CNT_TOP);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      case (op)
        CNT_LOAD: cnt_q <= load_val;
        CNT_ZERO: cnt_q <= '0;
        CNT_STEP: cnt_q <= cnt_q + CNT_ONE;
        default:  cnt_q <= cnt_q;
      endcase
    end
  end

  assign cnt_o = cnt_q;

  // R3
  cnt_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_o |=> cnt_q == '0);

  // R5
  cnt_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> cnt_q == $past(load_val));

endmodule

// File: rtl/tws_hold_ctl.sv
module tws_hold_ctl
  import tws_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic scl_fall,
  input  logic start,
  input  logic stop,
  input  logic wrap,
  input  logic start_clr,
  input  logic ovf_clr,
  input  logic stop_clr,
  output logic start_flag,
  output logic ovf_flag,
  output logic stop_flag,
  output logic scl_low
);

  logic start_q, ovf_q, stop_q;
  logic start_hold_q, ovf_hold_q;
  logic ovf_n;

  assign ovf_n = flag_next(wrap, ovf_clr, ovf_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      start_q      <= 1'b0;
      ovf_q        <= 1'b0;
      stop_q       <= 1'b0;
      start_hold_q <= 1'b0;
      ovf_hold_q   <= 1'b0;
    end else begin
      start_q <= flag_next(start, start_clr, start_q);
      ovf_q   <= ovf_n;
      stop_q  <= flag_next(stop, stop_clr, stop_q);
      start_hold_q <= flag_next(start, start_clr | stop, start_hold_q);
      if (stop || !ovf_n) ovf_hold_q <= 1'b0;
      else if (scl_fall)  ovf_hold_q <= 1'b1;
    end
  end

  assign start_flag = start_q;
  assign ovf_flag   = ovf_q;
  assign stop_flag  = stop_q;
  assign scl_low    = start_hold_q | ovf_hold_q;

  // R4
  ovf_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wrap |=> ovf_flag);

  // R6
  ovf_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_hold_q |-> ovf_flag);

  // R7
  start_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> start_flag && scl_low);

  // R8
  stop_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stop |=> stop_flag && !scl_low);

endmodule

// File: rtl/tws_target_engine.sv
module tws_target_engine
  import tws_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int CNT_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  input  logic              sr_wr,
  input  logic [DATA_W-1:0] sr_wdata,
  input  logic              cnt_wr,
  input  logic [CNT_W-1:0]  cnt_wdata,
  input  logic              start_clr,
  input  logic              ovf_clr,
  input  logic              stop_clr,
  input  logic              sda_oe,
  output logic [DATA_W-1:0] sr_q,
  output logic [CNT_W-1:0]  cnt_q,
  output logic              start_flag,
  output logic              ovf_flag,
  output logic              stop_flag,
  output logic              scl_low,
  output logic              sda_low
);

  tws_evt_t evt;
  logic     bus_edge;
  logic     cnt_wrap;

  tws_edge_det u_edge (
    .clk   (clk),
    .rst_n (rst_n),
    .scl_i (scl_i),
    .sda_i (sda_i),
    .evt_o (evt)
  );

  assign bus_edge = evt.scl_rise | evt.scl_fall;

  tws_shifter #(.DATA_W(DATA_W)) u_shift (
    .clk      (clk),
    .rst_n    (rst_n),
    .scl_rise (evt.scl_rise),
    .scl_fall (evt.scl_fall),
    .sda_i    (sda_i),
    .wr_en    (sr_wr),
    .wr_data  (sr_wdata),
    .sr_o     (sr_q)
  );

  tws_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk       (clk),
    .rst_n     (rst_n),
    .edge_seen (bus_edge),
    .start     (evt.start),
    .load      (cnt_wr),
    .load_val  (cnt_wdata),
    .cnt_o     (cnt_q),
    .wrap_o    (cnt_wrap)
  );

  tws_hold_ctl u_hold (
    .clk        (clk),
    .rst_n      (rst_n),
    .scl_fall   (evt.scl_fall),
    .start      (evt.start),
    .stop       (evt.stop),
    .wrap       (cnt_wrap),
    .start_clr  (start_clr),
    .ovf_clr    (ovf_clr),
    .stop_clr   (stop_clr),
    .start_flag (start_flag),
    .ovf_flag   (ovf_flag),
    .stop_flag  (stop_flag),
    .scl_low    (scl_low)
  );

  assign sda_low = sda_oe & ~sr_q[DATA_W-1];

  // R9
  sda_oe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sda_low |-> sda_oe && !sr_q[DATA_W-1]);

endmodule

// File: tb/tws_target_engine_test.sv
module tws_target_engine_test;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       scl_i, sda_i;
  logic       sr_wr;
  logic [7:0] sr_wdata;
  logic       cnt_wr;
  logic [3:0] cnt_wdata;
  logic       start_clr, ovf_clr, stop_clr, sda_oe;
  logic [7:0] sr_q;
  logic [3:0] cnt_q;
  logic       start_flag, ovf_flag, stop_flag, scl_low, sda_low;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // bench model state
  logic [7:0] m_sr;
  logic [3:0] m_cnt;
  logic m_bit, m_st, m_ov, m_sp, m_sh, m_oh, m_pscl, m_psda;
  logic cur_oe;

  always #2.5 clk = ~clk;

  tws_target_engine uut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .sr_wr(sr_wr), .sr_wdata(sr_wdata), .cnt_wr(cnt_wr), .cnt_wdata(cnt_wdata),
    .start_clr(start_clr), .ovf_clr(ovf_clr), .stop_clr(stop_clr), .sda_oe(sda_oe),
    .sr_q(sr_q), .cnt_q(cnt_q), .start_flag(start_flag), .ovf_flag(ovf_flag),
    .stop_flag(stop_flag), .scl_low(scl_low), .sda_low(sda_low)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic sticky(input logic set, input logic clr, input logic cur);
    if (set) return 1'b1;
    if (clr) return 1'b0;
    return cur;
  endfunction

  task automatic model(input logic scl, input logic sda, input logic sw, input logic [7:0] sd,
                       input logic cw, input logic [3:0] cd, input logic sc,
                       input logic oc, input logic pc);
    logic rise, fall, st, sp, wrap, ov_n;
    rise = scl && !m_pscl;
    fall = !scl && m_pscl;
    st   = m_pscl && scl && m_psda && !sda;
    sp   = m_pscl && scl && !m_psda && sda;
    wrap = (rise || fall) && !cw && !st && (m_cnt == 4'd15);
    if (cw) m_cnt = cd;
    else if (st) m_cnt = 4'd0;
    else if (rise || fall) m_cnt = m_cnt + 4'd1;
    if (sw) m_sr = sd;
    else if (fall) m_sr = {m_sr[6:0], m_bit};
    if (rise) m_bit = sda;
    ov_n = sticky(wrap, oc, m_ov);
    if (sp || !ov_n) m_oh = 1'b0;
    else if (fall) m_oh = 1'b1;
    m_ov = ov_n;
    m_sh = sticky(st, sc || sp, m_sh);
    m_st = sticky(st, sc, m_st);
    m_sp = sticky(sp, pc, m_sp);
    m_pscl = scl;
    m_psda = sda;
  endtask

  task automatic compare_all();
    chk("R2 shift register", sr_q, m_sr);
    chk("R3 counter", cnt_q, m_cnt);
    chk("R4 overflow flag", ovf_flag, m_ov);
    chk("R7 start flag", start_flag, m_st);
    chk("R8 stop flag", stop_flag, m_sp);
    chk("R6 R7 R8 clock hold", scl_low, m_sh | m_oh);
    chk("R9 data drive", sda_low, cur_oe & ~m_sr[7]);
  endtask

  task automatic step(input logic sm, input logic dm, input logic sw, input logic [7:0] sd,
                      input logic cw, input logic [3:0] cd, input logic sc, input logic oc,
                      input logic pc, input logic oe);
    @(negedge clk);
    sr_wr = sw; sr_wdata = sd; cnt_wr = cw; cnt_wdata = cd;
    start_clr = sc; ovf_clr = oc; stop_clr = pc; sda_oe = oe; cur_oe = oe;
    #1;
    scl_i = sm & ~scl_low;
    sda_i = dm & ~sda_low;
    model(scl_i, sda_i, sw, sd, cw, cd, sc, oc, pc);
    @(posedge clk);
    #1;
    compare_all();
  endtask

  task automatic bus(input logic sm, input logic dm);
    step(sm, dm, 1'b0, 8'h00, 1'b0, 4'h0, 1'b0, 1'b0, 1'b0, cur_oe);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] mbits;
    logic [7:0] rx;
    logic sm_r, dm_r, oe_r;
    void'($urandom(32'd20240611));
    rst_n = 1'b0; scl_i = 1'b1; sda_i = 1'b1;
    sr_wr = 0; sr_wdata = 0; cnt_wr = 0; cnt_wdata = 0;
    start_clr = 0; ovf_clr = 0; stop_clr = 0; sda_oe = 0; cur_oe = 0;
    m_sr = 0; m_cnt = 0; m_bit = 0; m_st = 0; m_ov = 0; m_sp = 0;
    m_sh = 0; m_oh = 0; m_pscl = 1; m_psda = 1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R1 reset state
    chk("R1 sr after reset", sr_q, 8'h00);
    chk("R1 counter after reset", cnt_q, 4'h0);
    chk("R1 flags after reset", {start_flag, ovf_flag, stop_flag}, 3'b000);
    chk("R1 lines after reset", {scl_low, sda_low}, 2'b00);

    // R7 start condition and hold
    bus(1, 1);
    bus(1, 0);
    chk("R7 start sets flag", start_flag, 1'b1);
    chk("R7 start holds clock", scl_low, 1'b1);
    chk("R7 start zeroes counter", cnt_q, 4'h0);
    // host acknowledges, preloads counter 0 and outgoing byte
    step(0, 0, 1'b1, 8'h5A, 1'b1, 4'd0, 1'b1, 1'b0, 1'b0, 1'b1);
    chk("R7 clear releases clock", scl_low, 1'b0);

    // R2 R6 full byte, wired-AND with target output 0x5A
    mbits = 8'($urandom());
    for (int i = 7; i >= 0; i--) begin
      bus(0, mbits[i]);
      bus(1, mbits[i]);
      bus(0, mbits[i]);
    end
    rx = mbits & 8'h5A;
    chk("R2 received byte", sr_q, rx);
    chk("R5 overflow after 16 edges", ovf_flag, 1'b1);
    chk("R6 hold after frame", scl_low, 1'b1);

    // R5 acknowledge phase with preload 14, target drives low
    step(0, 1, 1'b1, 8'h00, 1'b1, 4'd14, 1'b0, 1'b1, 1'b0, 1'b1);
    chk("R6 clear releases hold", scl_low, 1'b0);
    chk("R9 ack drives data low", sda_low, 1'b1);
    bus(1, 1);
    bus(0, 1);
    chk("R5 overflow after 2 edges", ovf_flag, 1'b1);
    chk("R5 counter wrapped", cnt_q, 4'h0);

    // R4 set and clear in the same cycle
    step(0, 1, 1'b0, 8'h00, 1'b1, 4'd15, 1'b0, 1'b1, 1'b0, 1'b0);
    step(1, 1, 1'b0, 8'h00, 1'b0, 4'd0, 1'b0, 1'b1, 1'b0, 1'b0);
    chk("R4 wrap beats clear", ovf_flag, 1'b1);
    step(1, 1, 1'b0, 8'h00, 1'b0, 4'd0, 1'b0, 1'b1, 1'b0, 1'b0);
    chk("R4 clear pulse", ovf_flag, 1'b0);

    // R10 host write in the same cycle as a falling edge
    step(0, 1, 1'b1, 8'hC3, 1'b1, 4'd3, 1'b0, 1'b0, 1'b0, 1'b0);
    chk("R10 write beats shift", sr_q, 8'hC3);
    chk("R5 load beats edge", cnt_q, 4'd3);

    // R8 stop condition with overflow pending and a start hold cleared
    step(0, 0, 1'b0, 8'h00, 1'b1, 4'd15, 1'b0, 1'b0, 1'b0, 1'b0);
    bus(1, 0);
    chk("R4 rise wrap sets flag", ovf_flag, 1'b1);
    bus(1, 1);
    chk("R8 stop sets flag", stop_flag, 1'b1);
    chk("R8 no hold after stop", scl_low, 1'b0);
    step(1, 1, 1'b0, 8'h00, 1'b0, 4'd0, 1'b0, 1'b1, 1'b1, 1'b0);
    chk("R8 stop clear", stop_flag, 1'b0);

    // random phase
    sm_r = 1; dm_r = 1; oe_r = 0;
    for (int n = 0; n < 6000; n++) begin
      logic [31:0] r;
      r = $urandom();
      if (r[0]) sm_r = ~sm_r;
      if (r[3:2] == 2'b00) dm_r = ~dm_r;
      if (r[7:4] == 4'h0) oe_r = ~oe_r;
      step(sm_r, dm_r, r[11:8] == 4'h0, r[23:16], r[15:12] == 4'h0, r[27:24],
           r[30:28] == 3'b000, r[31] & r[1], r[29] & r[5] & r[6], oe_r);
    end
    step(1, 1, 1'b0, 8'h00, 1'b0, 4'd0, 1'b1, 1'b1, 1'b1, 1'b0);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule